// File: doc/BRIEF.md
# Interrupt Source Enable Controller

This block gathers interrupt events from twelve sources and presents them to a host as a single interrupt line. There are four doorbell sources and eight DMA-channel sources. Each source delivers a one-cycle pulse, and the block latches that pulse into a sticky status bit. A status bit drives the output only when its per-source enable is set. Software turns enables on and off through two separate write-ones registers, one that sets and one that clears, so it never has to read and rewrite a shared mask to change a single source.

Software acknowledges events by reading the status register and writing the same value back. Only the bits written as one are cleared. A source can also be configured for automatic clearing. When its auto-clear bit is set, an external take strobe for that source clears the status bit without any bus write. This setting is meant for multi-vector operation. In single-vector operation software leaves the auto-clear mask at zero.

All registers are 32 bits wide and sit at fixed byte offsets. The bus has an address, a write strobe, a read strobe, write data and registered read data. The interrupt output is also registered.

Top module: `isc_intr_ctrl`

## Requirements
- R1: After synchronous reset, the status, enable and auto-clear registers are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A pulse on `db_src_i[i]` sets status bit i. A pulse on `dma_src_i[j]` sets status bit 4+j. Status, enable and auto-clear all read zero in bits 31:12.
- R3: A write to offset 0x4 sets every enable bit whose write-data bit is one and leaves the other enable bits unchanged. A read of 0x4 returns the enable mask.
- R4: A write to offset 0x8 clears every enable bit whose write-data bit is one and leaves the other enable bits unchanged. A read of 0x8 returns zero.
- R5: A read of offset 0x0 returns the status bits. A write to 0x0 clears exactly the status bits written as one.
- R6: A source pulse in the same cycle as a write to 0x0 that clears that bit leaves the bit set.
- R7: Offset 0xC is the read/write auto-clear mask. When `take_i[b]` is high and auto-clear bit b is set, status bit b is zero after that clock edge. When auto-clear bit b is zero, `take_i[b]` has no effect.
- R8: `irq_o` is high in the cycle after any status bit and its enable bit are both set, and low in the cycle after no such pair exists.
- R9: `rdata_o` changes only on the clock edge where `rd_i` is high, and shows the addressed register from that edge on. An unmapped address reads zero.
- R10: A source pulse in the same cycle as an enabled take strobe for that source leaves the status bit set.
- R11: A write to an address other than 0x0, 0x4, 0x8 or 0xC changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Byte address of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| db_src_i | input | 4 | Doorbell event pulses |
| dma_src_i | input | 8 | DMA channel event pulses |
| take_i | input | 12 | Per-source take strobes for auto-clear |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach is a collision: a source pulse lands on the same edge as something that clears its status bit, either a status write or an enabled take strobe. From the ports the two look like ordinary traffic, so the bench drives both on one falling edge, leaving the rising edge to see them together. It then reads status to confirm the bit survived. Around these cases the bench sweeps every source bit through the full sequence of latch, enable, interrupt, acknowledge and release. It also runs mask patterns through the enable and auto-clear registers.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int ISC_ADDR_W = 4;

  localparam logic [ISC_ADDR_W-1:0] OFS_STATUS = 4'h0;
  localparam logic [ISC_ADDR_W-1:0] OFS_EN_SET = 4'h4;
  localparam logic [ISC_ADDR_W-1:0] OFS_EN_CLR = 4'h8;
  localparam logic [ISC_ADDR_W-1:0] OFS_AUTO   = 4'hC;

  typedef struct packed {
    logic st_w1c;
    logic en_set;
    logic en_clr;
    logic ac_wr;
  } isc_wr_strobe_t;
endpackage

// File: rtl/isc_bus_decode.sv
module isc_bus_decode
  import isc_pkg::*;
(
  input  logic [ISC_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  output isc_wr_strobe_t        stb_o
);
  always_comb begin
    stb_o        = '0;
    stb_o.st_w1c = wr_i && (addr_i == OFS_STATUS);
    stb_o.en_set = wr_i && (addr_i == OFS_EN_SET);
    stb_o.en_clr = wr_i && (addr_i == OFS_EN_CLR);
    stb_o.ac_wr  = wr_i && (addr_i == OFS_AUTO);
  end
endmodule

// File: rtl/isc_mask_regs.sv
module isc_mask_regs #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            ac_wr_i,
  input  logic [NSRC-1:0] wmask_i,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] autoclr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o  <= '0;
      autoclr_o <= '0;
    end else begin
      if (en_set_i)      enable_o <= enable_o | wmask_i;
      else if (en_clr_i) enable_o <= enable_o & ~wmask_i;
      if (ac_wr_i)       autoclr_o <= wmask_i;
    end
  end

  assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
    en_set_i |=> ((enable_o & $past(wmask_i)) == $past(wmask_i)));
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
    en_clr_i |=> ((enable_o & $past(wmask_i)) == '0));
  assert_en_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (en_set_i || en_clr_i) |=> ((enable_o & ~$past(wmask_i)) == ($past(enable_o) & ~$past(wmask_i))));
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            w1c_i,
  input  logic [NSRC-1:0] wmask_i,
  input  logic [NSRC-1:0] take_i,
  input  logic [NSRC-1:0] autoclr_i,
  output logic [NSRC-1:0] status_o
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    logic clr_b;
    assign clr_b = (w1c_i && wmask_i[b]) || (take_i[b] && autoclr_i[b]);
    always_ff @(posedge clk) begin
      if (rst)         status_o[b] <= 1'b0;
      else if (src_i[b]) status_o[b] <= 1'b1;
      else if (clr_b)  status_o[b] <= 1'b0;
    end
  end

  assert_src_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((status_o & $past(src_i)) == $past(src_i)));
  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    w1c_i |=> ((status_o & $past(wmask_i & ~src_i)) == '0));
  assert_autoclr_R7: assert property (@(posedge clk) disable iff (rst)
    ((take_i & autoclr_i) != '0) |=> ((status_o & $past(take_i & autoclr_i & ~src_i)) == '0));
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] enable_i,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & enable_i);
  end
endmodule

// File: rtl/isc_intr_ctrl.sv
module isc_intr_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_DB  = 4,
  parameter int NUM_DMA = 8,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ISC_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_DB-1:0]     db_src_i,
  input  logic [NUM_DMA-1:0]    dma_src_i,
  input  logic [NUM_DB+NUM_DMA-1:0] take_i,
  output logic                  irq_o
);
  localparam int NSRC = NUM_DB + NUM_DMA;

  isc_wr_strobe_t  stb;
  logic [NSRC-1:0] wmask, src_vec, status_q, en_q, ac_q;
  logic            unused_hi;

  assign wmask     = wdata_i[NSRC-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:NSRC];
  assign src_vec   = {dma_src_i, db_src_i};

  isc_bus_decode u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .stb_o  (stb)
  );

  isc_mask_regs #(.NSRC(NSRC)) u_masks (
    .clk       (clk),
    .rst       (rst),
    .en_set_i  (stb.en_set),
    .en_clr_i  (stb.en_clr),
    .ac_wr_i   (stb.ac_wr),
    .wmask_i   (wmask),
    .enable_o  (en_q),
    .autoclr_o (ac_q)
  );

  isc_status_bank #(.NSRC(NSRC)) u_status (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_vec),
    .w1c_i     (stb.st_w1c),
    .wmask_i   (wmask),
    .take_i    (take_i),
    .autoclr_i (ac_q),
    .status_o  (status_q)
  );

  isc_irq_out #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_q),
    .enable_i (en_q),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= '0;
      case (addr_i)
        OFS_STATUS: rdata_o[NSRC-1:0] <= status_q;
        OFS_EN_SET: rdata_o[NSRC-1:0] <= en_q;
        OFS_AUTO:   rdata_o[NSRC-1:0] <= ac_q;
        default:    rdata_o <= '0;
      endcase
    end
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rdata_o[DATA_W-1:NSRC] == '0);
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past((status_q & en_q) != '0));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/isc_intr_ctrl_test.sv
module isc_intr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  db = '0;
  logic [7:0]  dma = '0;
  logic [11:0] take = '0;
  logic        irq;
  int total = 0, bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  isc_intr_ctrl uut (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .db_src_i(db), .dma_src_i(dma),
    .take_i(take), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input [31:0] got, input [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input [3:0] a, input [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input [3:0] a, output [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input [11:0] s);
    @(negedge clk); db = s[3:0]; dma = s[11:4];
    @(negedge clk); db = '0; dma = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({31'd0, irq}, 0, "R1 irq after reset");
    chk(rdata, 0, "R1 rdata after reset");
    bus_rd(4'h0, v); chk(v, 0, "R1 status reset");
    bus_rd(4'h4, v); chk(v, 0, "R1 enable reset");
    bus_rd(4'hC, v); chk(v, 0, "R1 autoclr reset");

    // sweep each source: R2 latch, R8 irq, R5 ack
    for (int b = 0; b < 12; b++) begin
      pulse(12'(1 << b));
      bus_rd(4'h0, v); chk(v, 32'(1 << b), "R2 source latch");
      chk({31'd0, irq}, 0, "R8 irq masked");
      bus_wr(4'h4, 32'(1 << b));
      @(negedge clk); chk({31'd0, irq}, 1, "R8 irq enabled");
      bus_wr(4'h0, 32'(1 << b));
      @(negedge clk); chk({31'd0, irq}, 0, "R8 irq after ack");
      bus_rd(4'h0, v); chk(v, 0, "R5 status cleared");
      bus_wr(4'h8, 32'(1 << b));
    end

    // enable set/clear patterns
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_rd(4'h4, v); chk(v, 32'hFFF, "R2 R3 enable upper zero");
    bus_wr(4'h8, 32'h0A5);
    bus_rd(4'h4, v); chk(v, 32'hF5A, "R4 enable clear pattern");
    bus_wr(4'h4, 32'h001);
    bus_rd(4'h4, v); chk(v, 32'hF5B, "R3 enable set keeps others");
    bus_rd(4'h8, v); chk(v, 0, "R4 clear reg reads zero");
    bus_wr(4'h6, 32'hFFF);
    bus_rd(4'h4, v); chk(v, 32'hF5B, "R11 unmapped write ignored");
    bus_rd(4'h6, v); chk(v, 0, "R9 unmapped read zero");
    bus_wr(4'h4, 32'h0);
    bus_rd(4'h4, v); chk(v, 32'hF5B, "R3 zero write no effect");

    // partial acknowledge
    pulse(12'hFFF);
    bus_wr(4'h0, 32'h3C3);
    bus_rd(4'h0, v); chk(v, 32'hC3C, "R5 partial ack");
    bus_wr(4'h0, 32'hFFF);

    // auto-clear
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, v); chk(v, 32'hFFF, "R2 R7 autoclr upper zero");
    bus_wr(4'hC, 32'hF0F);
    bus_rd(4'hC, v); chk(v, 32'hF0F, "R7 autoclr readback");
    pulse(12'hFFF);
    @(negedge clk); take = 12'hFFF;
    @(negedge clk); take = '0;
    bus_rd(4'h0, v); chk(v, 32'h0F0, "R7 take clears only autoclr bits");

    // R10: source and take together
    @(negedge clk); db = 4'h1; take = 12'h001;
    @(negedge clk); db = '0; take = '0;
    bus_rd(4'h0, v); chk(v, 32'h0F1, "R10 source beats take");

    // R6: source and W1C together on bit 1 (set first)
    pulse(12'h002);
    @(negedge clk); addr = 4'h0; wdata = 32'h002; wr = 1'b1; db = 4'h2;
    @(negedge clk); wr = 1'b0; db = '0;
    bus_rd(4'h0, v); chk(v, 32'h0F3, "R6 source beats ack");

    // R9 hold without read
    @(negedge clk); @(negedge clk);
    chk(rdata, 32'h0F3, "R9 rdata holds");
    bus_wr(4'h0, 32'hFFF);
    chk(rdata, 32'h0F3, "R9 rdata holds after write");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule